// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Front End

This block is the synchronous digital front end of a four-channel, 12-bit voltage-output converter. A host writes codes over a parallel bus into one staging register per channel. It picks the channel with a 2-bit address and strobes an active-low select together with the first write strobe. A second strobe, combined with an active-low transfer, copies every staging register into its channel's output register at the same time. The same strobe combined with an active-low clear writes the mid-scale code instead. In offset binary, mid-scale means zero output.

A bus-width select lets a narrow host build a full word in two writes. With the select high, the full word is loaded. With it low, only the low nibble is loaded, and that nibble is taken from the top four bus lines. The output register keeps the three most significant code bits as seven equally weighted thermometer lines beside the nine low bits. For checking, the block also rebuilds a plain offset-binary code from those fields. When the transfer path is held open, the output registers follow the staging registers, so a single strobe updates one channel. Holding clear low in that state masks every output to mid-scale until clear is released.

The level-sensitive latches are modelled as registers that sample their enables on each rising clock edge. A latch whose enable stays asserted for several cycles keeps following its source.

Top module: `qdac_front`

## Requirements
- R1: Channel address 0, 1, 2 and 3 select channel 1, 2, 3 and 4, which are output slots 0 to 3 of each packed output, lowest slot in the lowest bits. A write changes only the addressed staging register.
- R2: A staging register is written at a rising edge only if `sel_n` and `wstb1_n` are both low at that edge. Otherwise no staging register changes.
- R3: With `wide_mode` high, a write loads all 12 bus bits unchanged into the addressed staging register.
- R4: With `wide_mode` low, a write loads bus bits 11..8 into staging bits 3..0 and leaves staging bits 11..4 unchanged.
- R5: At an edge where `wstb2_n` and `xfer_n` are both low, every output register takes its staging register's value from before that edge. At any edge where `wstb2_n` is high, every output register keeps its value.
- R6: At an edge where `wstb2_n` and `clr_n` are low and `xfer_n` is high, every output register is loaded with 0x800.
- R7: After an edge where `wstb2_n`, `xfer_n` and `clr_n` are all low, every output shows 0x800. After an edge with `clr_n` high, the held register codes appear again.
- R8: During and after reset, all staging and output registers hold 0x800.
- R9: In each channel's `code_therm` slot, bit i (i = 0..6) is 1 exactly when code bits 11..9 exceed i. The `code_low` slot carries code bits 8..0.
- R10: With `sel_n`, `wstb2_n` and `xfer_n` held low, a one-cycle `wstb1_n` pulse changes only the addressed channel's output, one edge after the write edge.
- R11: Each `code_ob` slot equals the number of ones in its thermometer slot, placed in bits 11..9, joined with its low slot in bits 8..0. It changes on the edge after the controlling inputs are sampled.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 12 | Parallel data bus |
| chan_sel | input | 2 | Channel address |
| sel_n | input | 1 | Active-low chip select |
| wstb1_n | input | 1 | Active-low staging write strobe |
| wstb2_n | input | 1 | Active-low output-register strobe |
| xfer_n | input | 1 | Active-low simultaneous transfer |
| clr_n | input | 1 | Active-low clear to mid-scale |
| wide_mode | input | 1 | 1: full-word load, 0: low-nibble load from bus bits 11..8 |
| code_therm | output | 28 | Seven thermometer lines per channel |
| code_low | output | 36 | Nine low code bits per channel |
| code_ob | output | 48 | Rebuilt 12-bit offset-binary code per channel |

## Verification
A staging write takes effect at the edge that samples it, but the outputs only show it after a transfer. A transfer, a clear or a force sampled at edge k shows up on the outputs right after edge k. So in pass-through, a code written at edge k is visible after edge k+1. The bench drives inputs on the falling edge and updates its reference model at the rising edge. When it updates the model, it computes the output registers from the staging values held before that edge. It compares all three output fields on the following falling edge, half a period after the edge that should have produced them.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   // operation applied to the output registers at a clock edge
   typedef enum logic [1:0] {
      DOP_HOLD = 2'd0,
      DOP_LOAD = 2'd1,
      DOP_MID  = 2'd2
   } dac_op_e;

   // mid-scale code of a CW-bit offset binary word
   function automatic logic [31:0] mid_code(input int cw);
      return 32'd1 << (cw - 1);
   endfunction
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
   import qdac_pkg::*;
#(
   parameter int NCH = 4,
   localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0]  chan_sel,
   input  logic           sel_n,
   input  logic           wstb1_n,
   input  logic           wstb2_n,
   input  logic           xfer_n,
   input  logic           clr_n,
   output logic [NCH-1:0] stage_we,
   output dac_op_e        dac_op,
   output logic           force_mid
);
   logic write_go;

   assign write_go = ~sel_n & ~wstb1_n;

   for (genvar c = 0; c < NCH; c++) begin : g_dec
      assign stage_we[c] = write_go && (chan_sel == AW'(c));
   end

   always_comb begin
      dac_op = DOP_HOLD;
      if (!wstb2_n) begin
         if (!xfer_n)     dac_op = DOP_LOAD;
         else if (!clr_n) dac_op = DOP_MID;
      end
   end

   assign force_mid = ~wstb2_n & ~xfer_n & ~clr_n;
endmodule

// File: rtl/qdac_stage_reg.sv
module qdac_stage_reg #(
   parameter int CW        = 12,
   parameter int NARROW_W  = 8,
   parameter bit BYTE_PATH = 1'b1,
   localparam int NIB_W    = CW - NARROW_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wide,
   input  logic [CW-1:0] bus,
   output logic [CW-1:0] stage_q
);
   localparam logic [CW-1:0] MID = CW'(qdac_pkg::mid_code(CW));

   if (BYTE_PATH) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= MID;
         end else if (we) begin
            if (wide) stage_q <= bus;
            else      stage_q[NIB_W-1:0] <= bus[CW-1 -: NIB_W];
         end
      end
   end else begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  stage_q <= MID;
         else if (we) stage_q <= bus;
      end
   end
endmodule

// File: rtl/qdac_seg_reg.sv
module qdac_seg_reg
   import qdac_pkg::*;
#(
   parameter int CW   = 12,
   parameter int SEGB = 3,
   localparam int LOWW = CW - SEGB,
   localparam int THW  = (1 << SEGB) - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  dac_op_e         op,
   input  logic [CW-1:0]   src,
   output logic [THW-1:0]  therm_q,
   output logic [LOWW-1:0] low_q
);
   localparam logic [CW-1:0] MID = CW'(qdac_pkg::mid_code(CW));

   logic [THW-1:0] src_therm;
   logic [THW-1:0] mid_therm;
   logic [SEGB-1:0] src_top;

   assign src_top = src[CW-1 -: SEGB];

   for (genvar i = 0; i < THW; i++) begin : g_enc
      assign src_therm[i] = (src_top > SEGB'(i));
      assign mid_therm[i] = (MID[CW-1 -: SEGB] > SEGB'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm_q <= mid_therm;
         low_q   <= MID[LOWW-1:0];
      end else begin
         case (op)
            DOP_LOAD: begin
               therm_q <= src_therm;
               low_q   <= src[LOWW-1:0];
            end
            DOP_MID: begin
               therm_q <= mid_therm;
               low_q   <= MID[LOWW-1:0];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/qdac_seg_join.sv
module qdac_seg_join #(
   parameter int CW   = 12,
   parameter int SEGB = 3,
   localparam int LOWW = CW - SEGB,
   localparam int THW  = (1 << SEGB) - 1
) (
   input  logic            force_mid,
   input  logic [THW-1:0]  therm_in,
   input  logic [LOWW-1:0] low_in,
   output logic [CW-1:0]   held_code,
   output logic [THW-1:0]  therm_out,
   output logic [LOWW-1:0] low_out,
   output logic [CW-1:0]   code_out
);
   localparam logic [CW-1:0] MID = CW'(qdac_pkg::mid_code(CW));

   logic [SEGB-1:0] top_cnt;
   logic [THW-1:0]  mid_therm;

   for (genvar i = 0; i < THW; i++) begin : g_mid
      assign mid_therm[i] = (MID[CW-1 -: SEGB] > SEGB'(i));
   end

   always_comb begin
      top_cnt = '0;
      for (int i = 0; i < THW; i++) top_cnt = top_cnt + SEGB'(therm_in[i]);
   end

   assign held_code = {top_cnt, low_in};
   assign therm_out = force_mid ? mid_therm : therm_in;
   assign low_out   = force_mid ? MID[LOWW-1:0] : low_in;
   assign code_out  = force_mid ? MID : held_code;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
   import qdac_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int CW        = 12,
   parameter int SEGB      = 3,
   parameter int NARROW_W  = 8,
   parameter bit BYTE_PATH = 1'b1,
   localparam int AW   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int LOWW = CW - SEGB,
   localparam int THW  = (1 << SEGB) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     bus_d,
   input  logic [AW-1:0]     chan_sel,
   input  logic              sel_n,
   input  logic              wstb1_n,
   input  logic              wstb2_n,
   input  logic              xfer_n,
   input  logic              clr_n,
   input  logic              wide_mode,
   output logic [NCH*THW-1:0]  code_therm,
   output logic [NCH*LOWW-1:0] code_low,
   output logic [NCH*CW-1:0]   code_ob
);
   if (NCH < 1)                                 begin : g_bad_nch  $error("NCH must be at least 1"); end
   if (SEGB < 1 || SEGB >= CW)                  begin : g_bad_segb $error("SEGB must be in 1..CW-1"); end
   if (BYTE_PATH && (NARROW_W >= CW))           begin : g_bad_nw   $error("NARROW_W must be below CW"); end
   if (BYTE_PATH && (CW - NARROW_W > NARROW_W)) begin : g_bad_nib  $error("nibble wider than narrow bus"); end

   logic [NCH-1:0]    stage_we;
   dac_op_e           dac_op;
   logic              force_q;
   logic              force_next;
   logic [NCH*CW-1:0] stage_flat;
   logic [NCH*CW-1:0] held_flat;

   qdac_ctrl #(.NCH(NCH)) u_ctrl (
      .chan_sel (chan_sel),
      .sel_n    (sel_n),
      .wstb1_n  (wstb1_n),
      .wstb2_n  (wstb2_n),
      .xfer_n   (xfer_n),
      .clr_n    (clr_n),
      .stage_we (stage_we),
      .dac_op   (dac_op),
      .force_mid(force_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) force_q <= 1'b0;
      else        force_q <= force_next;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [THW-1:0]  therm_q;
      logic [LOWW-1:0] low_q;

      qdac_stage_reg #(.CW(CW), .NARROW_W(NARROW_W), .BYTE_PATH(BYTE_PATH)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (stage_we[c]),
         .wide   (wide_mode),
         .bus    (bus_d),
         .stage_q(stage_flat[c*CW +: CW])
      );

      qdac_seg_reg #(.CW(CW), .SEGB(SEGB)) u_seg (
         .clk    (clk),
         .rst_n  (rst_n),
         .op     (dac_op),
         .src    (stage_flat[c*CW +: CW]),
         .therm_q(therm_q),
         .low_q  (low_q)
      );

      qdac_seg_join #(.CW(CW), .SEGB(SEGB)) u_join (
         .force_mid(force_q),
         .therm_in (therm_q),
         .low_in   (low_q),
         .held_code(held_flat[c*CW +: CW]),
         .therm_out(code_therm[c*THW +: THW]),
         .low_out  (code_low[c*LOWW +: LOWW]),
         .code_out (code_ob[c*CW +: CW])
      );
   end
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
   parameter int NCH  = 4,
   parameter int CW   = 12,
   parameter int SEGB = 3,
   localparam int THW = (1 << SEGB) - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              wstb1_n,
   input logic              wstb2_n,
   input logic              xfer_n,
   input logic              clr_n,
   input logic [NCH*CW-1:0] stage_flat,
   input logic [NCH*CW-1:0] held_flat,
   input logic [NCH*THW-1:0] code_therm,
   input logic [NCH*CW-1:0] code_ob
);
   localparam logic [CW-1:0]     MID     = CW'(qdac_pkg::mid_code(CW));
   localparam logic [NCH*CW-1:0] ALL_MID = {NCH{MID}};

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || wstb1_n) |=> $stable(stage_flat)); // R2

   AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (!wstb2_n && !xfer_n) |=> (held_flat == $past(stage_flat))); // R5

   AST_OUTREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wstb2_n |=> $stable(held_flat)); // R5

   AST_CLEAR_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (!wstb2_n && xfer_n && !clr_n) |=> (held_flat == ALL_MID)); // R6

   AST_FORCE_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (!wstb2_n && !xfer_n && !clr_n) |=> (code_ob == ALL_MID)); // R7

   AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_n |=> (code_ob == held_flat)); // R7

   for (genvar c = 0; c < NCH; c++) begin : g_th
      AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
         ((code_therm[c*THW +: THW] & (code_therm[c*THW +: THW] + THW'(1))) == '0)); // R9
   end
endmodule

bind qdac_front qdac_front_chk #(.NCH(NCH), .CW(CW), .SEGB(SEGB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_n     (sel_n),
   .wstb1_n   (wstb1_n),
   .wstb2_n   (wstb2_n),
   .xfer_n    (xfer_n),
   .clr_n     (clr_n),
   .stage_flat(stage_flat),
   .held_flat (held_flat),
   .code_therm(code_therm),
   .code_ob   (code_ob)
);

// File: tb/qdac_front_test.sv
module qdac_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = 12;
   localparam int THW = 7;
   localparam int LW  = 9;
   localparam logic [11:0] MID = 12'h800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [11:0] bus_d = '0;
   logic [1:0]  chan_sel = '0;
   logic sel_n = 1'b1, wstb1_n = 1'b1, wstb2_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
   logic wide_mode = 1'b1;
   logic [NCH*THW-1:0] code_therm;
   logic [NCH*LW-1:0]  code_low;
   logic [NCH*CW-1:0]  code_ob;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [11:0] m_stage [NCH];
   logic [11:0] m_out   [NCH];
   logic        m_force;

   always #(CLK_PERIOD/2) clk = ~clk;

   qdac_front uut (
      .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .chan_sel(chan_sel),
      .sel_n(sel_n), .wstb1_n(wstb1_n), .wstb2_n(wstb2_n), .xfer_n(xfer_n),
      .clr_n(clr_n), .wide_mode(wide_mode),
      .code_therm(code_therm), .code_low(code_low), .code_ob(code_ob)
   );

   function automatic logic [6:0] exp_therm(input logic [11:0] c);
      logic [6:0] t;
      for (int i = 0; i < 7; i++) t[i] = (c[11:9] > 3'(i));
      return t;
   endfunction

   function automatic logic [11:0] exp_code(input int ch);
      return m_force ? MID : m_out[ch];
   endfunction

   // reference step: output registers use staging values from before the edge
   task automatic model_edge();
      if (!wstb2_n && !xfer_n) begin
         for (int c = 0; c < NCH; c++) m_out[c] = m_stage[c];
      end else if (!wstb2_n && !clr_n) begin
         for (int c = 0; c < NCH; c++) m_out[c] = MID;
      end
      m_force = !wstb2_n && !xfer_n && !clr_n;
      if (!sel_n && !wstb1_n) begin
         if (wide_mode) m_stage[chan_sel] = bus_d;
         else           m_stage[chan_sel][3:0] = bus_d[11:8];
      end
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < NCH; c++) begin
         logic [11:0] e;
         e = exp_code(c);
         total++;
         if (code_ob[c*CW +: CW] !== e) begin
            bad++;
            $display("FAIL %s ch%0d code actual=%h expected=%h", tag, c, code_ob[c*CW +: CW], e);
         end
         total++;
         if (code_therm[c*THW +: THW] !== exp_therm(e) || code_low[c*LW +: LW] !== e[8:0]) begin
            bad++;
            $display("FAIL R9 ch%0d fields actual=%b/%h expected=%b/%h", c,
                     code_therm[c*THW +: THW], code_low[c*LW +: LW], exp_therm(e), e[8:0]);
         end
      end
   endtask

   task automatic check_val(input int ch, input logic [11:0] e, input string tag);
      total++;
      if (code_ob[ch*CW +: CW] !== e) begin
         bad++;
         $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, code_ob[ch*CW +: CW], e);
      end
   endtask

   task automatic cyc(input logic [11:0] d, input logic [1:0] a, input logic cs, input logic w1,
                      input logic w2, input logic xf, input logic cl, input logic wd, input string tag);
      bus_d = d; chan_sel = a; sel_n = cs; wstb1_n = w1; wstb2_n = w2;
      xfer_n = xf; clr_n = cl; wide_mode = wd;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic idle(input string tag);
      cyc(12'h000, 2'd0, 1, 1, 1, 1, 1, 1, tag);
   endtask

   task automatic xfer_pulse(input string tag);
      cyc(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, tag);
      idle(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int c = 0; c < NCH; c++) begin m_stage[c] = MID; m_out[c] = MID; end
      m_force = 1'b0;
      @(negedge clk);
      // R8: reset state
      for (int c = 0; c < NCH; c++) check_val(c, MID, "R8");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R8");
      xfer_pulse("R8");
      for (int c = 0; c < NCH; c++) check_val(c, MID, "R8");

      // R1 / R3: wide write to address 2 lands in channel 3 only
      cyc(12'hABC, 2'd2, 0, 0, 1, 1, 1, 1, "R3");
      idle("R1");
      check_val(2, MID, "R5");
      xfer_pulse("R1");
      check_val(2, 12'hABC, "R3");
      check_val(0, MID, "R1");
      check_val(3, MID, "R1");

      // R2: strobes not both low, no staging change
      cyc(12'h123, 2'd0, 1, 0, 1, 1, 1, 1, "R2");
      cyc(12'h456, 2'd0, 0, 1, 1, 1, 1, 1, "R2");
      xfer_pulse("R2");
      check_val(0, MID, "R2");

      // R4: high byte then low nibble from bus 11..8
      cyc(12'h5A0, 2'd1, 0, 0, 1, 1, 1, 1, "R3");
      cyc(12'hF37, 2'd1, 0, 0, 1, 1, 1, 0, "R4");
      xfer_pulse("R4");
      check_val(1, 12'h5AF, "R4");

      // R6: clear with transfer high
      cyc(12'h000, 2'd0, 1, 1, 0, 1, 0, 1, "R6");
      for (int c = 0; c < NCH; c++) check_val(c, MID, "R6");
      idle("R6");
      xfer_pulse("R5");
      check_val(1, 12'h5AF, "R5");

      // R7: force while transfer open, then release
      cyc(12'h000, 2'd0, 1, 1, 0, 0, 0, 1, "R7");
      check_val(1, MID, "R7");
      check_val(2, MID, "R7");
      cyc(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, "R7");
      check_val(1, 12'h5AF, "R7");
      check_val(2, 12'hABC, "R7");

      // R10: pass-through, one strobe updates one channel
      cyc(12'hFFF, 2'd3, 0, 0, 0, 0, 1, 1, "R10");
      check_val(3, MID, "R10");
      cyc(12'hFFF, 2'd3, 0, 1, 0, 0, 1, 1, "R10");
      check_val(3, 12'hFFF, "R10");
      check_val(0, MID, "R10");
      cyc(12'h001, 2'd0, 0, 0, 0, 0, 1, 1, "R10");
      cyc(12'h001, 2'd0, 0, 1, 0, 0, 1, 1, "R10");
      check_val(0, 12'h001, "R10");
      check_val(3, 12'hFFF, "R10");

      // corners for R9: zero and full scale fields already covered; random mix
      for (int n = 0; n < 4000; n++) begin
         cyc(12'($urandom), 2'($urandom),
             ($urandom % 10) < 3, ($urandom % 2) == 0 ? 1'b0 : 1'b1,
             ($urandom % 10) < 6, ($urandom % 2) == 1,
             ($urandom % 10) < 8, ($urandom % 10) < 7, "R11");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule